// File: doc/BRIEF.md
# SHA-256 Block Engine with RAM-Resident Context

This engine performs one SHA-256 compression step on a 512-bit message block. It keeps no message, chaining value or round constants of its own between operations. All of that lives in a shared local RAM, and the engine reaches it through a 32-bit word-addressed master port. Software writes a context block into RAM: sixteen message words, eight reserved words, then eight chaining words. It also places the 64 round constants in a second RAM region. It then points two base registers at those regions and sets the start flag.

Once started, the engine takes the memory port for the whole operation. It reads the chaining words, streams the message words into a rolling 16-word schedule buffer, and runs 64 rounds, reading one round constant per round. It then writes the new chaining value back over the old one in place. Message padding, length counting and byte-order fixes are left to software. Each RAM word is used as a 32-bit value exactly as stored. Chaining several blocks means reloading the message words and starting again, and the engine picks up the chaining words it wrote last time.

Top module: `sha_ctx_engine`

## Requirements
- R1: After reset, all three registers read 0x00 and the memory request output is low.
- R2: Register offset 0 is control, offset 1 is the context base and offset 2 is the constant base. Control bits other than bit 1 read back as written. A base register keeps bits [7:2] and reads bits [1:0] as 0.
- R3: Writing control with bit 1 set while idle starts an operation. Bit 1 reads 1 from the cycle after that write until the operation ends, and then reads 0.
- R4: Chaining word i is held at context word 24+i, and message word t at context word t. A base field f places its region at word address f*64, which is byte address f*256. After an operation, words 24..31 hold the SHA-256 compression of the old chaining value and message words 0..15. Round constant j is read from word j of the constant region.
- R5: During an operation the engine writes only context words 24..31, exactly eight writes per operation. Message words and reserved words 16..23 keep their values. All accesses fall inside the two regions.
- R6: A start write made while an operation is running has no effect. No second operation follows, and the write count of the running one stays at eight.
- R7: The engine waits while mem_ready is low. Address, write enable and write data hold steady until the request is accepted, and the result is unchanged by wait states. Read data is taken one cycle after the read is accepted.
- R8: No memory request is raised while the engine is idle.
- R9: Successive operations on one context chain correctly, because each one reads back the chaining words the previous one wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a read is accepted |

## Verification
The start flag is registered, so control bit 1 reads 1 on the first cycle after the start write. The bench reads it there. With no wait states an operation takes 185 cycles after that flag is set: 2 cycles for each of the 88 reads, 1 for each of the 8 writes, and a closing cycle. Wait states stretch this, so the bench does not count to a fixed cycle. It polls the control register once per cycle until bit 1 clears, with a bounded timeout. Only then does it compare the RAM against its own SHA-256 model.

// File: rtl/sha_ctx_pkg.sv
package sha_ctx_pkg;

  localparam int WORD_W     = 32;
  localparam int HASH_WORDS = 8;
  localparam int MSG_WORDS  = 16;
  localparam int NUM_ROUNDS = 64;
  localparam int H_OFS      = 24;   // word offset of chaining words inside the context

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FH,
    ST_FW,
    ST_RND,
    ST_WB,
    ST_DONE
  } st_e;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

endpackage

// File: rtl/sha_ctx_regs.sv
module sha_ctx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [DW-1:0] rdata,
  output logic          start,
  output logic [DW-3:0] ctx_base,
  output logic [DW-3:0] k_base
);

  localparam int FW      = DW - 2;
  localparam int GO_BIT  = 1;

  logic [DW-1:0] ctrl_q;
  logic [FW-1:0] ctx_q;
  logic [FW-1:0] kb_q;
  logic          start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ctx_q   <= '0;
      kb_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          2'd0: begin
            ctrl_q <= wdata;
            if (wdata[GO_BIT] && !busy && !start_q) start_q <= 1'b1;
          end
          2'd1: ctx_q <= wdata[DW-1:2];
          2'd2: kb_q  <= wdata[DW-1:2];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata         = ctrl_q;
        rdata[GO_BIT] = busy | start_q;
      end
      2'd1: rdata = {ctx_q, 2'b00};
      2'd2: rdata = {kb_q, 2'b00};
      default: rdata = '0;
    endcase
  end

  assign start    = start_q;
  assign ctx_base = ctx_q;
  assign k_base   = kb_q;

endmodule

// File: rtl/sha_ctx_round.sv
module sha_ctx_round
  import sha_ctx_pkg::*;
(
  input  word_t [HASH_WORDS-1:0] v_in,
  input  word_t                  k_in,
  input  word_t                  w_in,
  input  word_t                  w_m15,
  input  word_t                  w_m7,
  input  word_t                  w_m2,
  output word_t [HASH_WORDS-1:0] v_out,
  output word_t                  w_new
);

  word_t t1;
  word_t t2;

  always_comb begin
    t1 = v_in[7] + big_s1(v_in[4]) + f_ch(v_in[4], v_in[5], v_in[6]) + k_in + w_in;
    t2 = big_s0(v_in[0]) + f_maj(v_in[0], v_in[1], v_in[2]);
    v_out[0] = t1 + t2;
    v_out[1] = v_in[0];
    v_out[2] = v_in[1];
    v_out[3] = v_in[2];
    v_out[4] = v_in[3] + t1;
    v_out[5] = v_in[4];
    v_out[6] = v_in[5];
    v_out[7] = v_in[6];
  end

  // schedule word sixteen steps ahead of the one consumed this round
  assign w_new = sml_s1(w_m2) + w_m7 + sml_s0(w_m15) + w_in;

endmodule

// File: rtl/sha_ctx_seq.sv
module sha_ctx_seq
  import sha_ctx_pkg::*;
#(
  parameter int BASE_BITS   = 6,
  parameter int ALIGN_BYTES = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [BASE_BITS-1:0]  ctx_base,
  input  logic [BASE_BITS-1:0]  k_base,
  output logic                  busy,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [BASE_BITS+$clog2(ALIGN_BYTES/4)-1:0] mem_addr,
  output word_t                 mem_wdata,
  input  logic                  mem_ready,
  input  word_t                 mem_rdata
);

  localparam int OFS_W = $clog2(ALIGN_BYTES / 4);
  localparam int CNT_W = $clog2(NUM_ROUNDS);
  localparam int HI_W  = $clog2(HASH_WORDS);
  localparam logic [OFS_W-1:0] H_OFS_V = OFS_W'(H_OFS);

  st_e                    state;
  logic [CNT_W-1:0]       cnt;
  logic                   req_q;
  logic                   we_q;
  logic                   pend_q;
  logic [BASE_BITS-1:0]   ctx_q;
  logic [BASE_BITS-1:0]   kb_q;
  logic                   last;
  logic [HI_W-1:0]        hidx;

  word_t                  h_q [HASH_WORDS];
  word_t [HASH_WORDS-1:0] v_q;
  word_t [HASH_WORDS-1:0] v_next;
  word_t                  w_q [MSG_WORDS];
  word_t                  w_new;

  assign hidx = cnt[HI_W-1:0];

  always_comb begin
    case (state)
      ST_FH:   last = (cnt == CNT_W'(HASH_WORDS - 1));
      ST_FW:   last = (cnt == CNT_W'(MSG_WORDS - 1));
      ST_RND:  last = (cnt == CNT_W'(NUM_ROUNDS - 1));
      ST_WB:   last = (cnt == CNT_W'(HASH_WORDS - 1));
      default: last = 1'b0;
    endcase
  end

  // control and memory handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      pend_q <= 1'b0;
      ctx_q  <= '0;
      kb_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            ctx_q <= ctx_base;
            kb_q  <= k_base;
            cnt   <= '0;
            req_q <= 1'b1;
            we_q  <= 1'b0;
            state <= ST_FH;
          end
        end
        ST_FH, ST_FW, ST_RND: begin
          if (req_q && mem_ready) begin
            req_q  <= 1'b0;
            pend_q <= 1'b1;
          end
          if (pend_q) begin
            pend_q <= 1'b0;
            req_q  <= 1'b1;
            if (last) begin
              cnt <= '0;
              if (state == ST_RND) begin
                we_q  <= 1'b1;
                state <= ST_WB;
              end else begin
                state <= (state == ST_FH) ? ST_FW : ST_RND;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_WB: begin
          if (req_q && mem_ready) begin
            if (last) begin
              req_q <= 1'b0;
              we_q  <= 1'b0;
              cnt   <= '0;
              state <= ST_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // datapath: chaining copy, working variables and rolling schedule
  always_ff @(posedge clk) begin
    if (pend_q) begin
      case (state)
        ST_FH: begin
          h_q[hidx] <= mem_rdata;
          v_q[hidx] <= mem_rdata;
        end
        ST_FW: begin
          for (int i = 0; i < MSG_WORDS - 1; i++) w_q[i] <= w_q[i+1];
          w_q[MSG_WORDS-1] <= mem_rdata;
        end
        ST_RND: begin
          v_q <= v_next;
          for (int i = 0; i < MSG_WORDS - 1; i++) w_q[i] <= w_q[i+1];
          w_q[MSG_WORDS-1] <= w_new;
        end
        default: ;
      endcase
    end
  end

  sha_ctx_round u_round (
    .v_in  (v_q),
    .k_in  (mem_rdata),
    .w_in  (w_q[0]),
    .w_m15 (w_q[1]),
    .w_m7  (w_q[9]),
    .w_m2  (w_q[14]),
    .v_out (v_next),
    .w_new (w_new)
  );

  always_comb begin
    case (state)
      ST_FH, ST_WB: mem_addr = {ctx_q, H_OFS_V + OFS_W'(cnt)};
      ST_FW:        mem_addr = {ctx_q, OFS_W'(cnt)};
      ST_RND:       mem_addr = {kb_q, OFS_W'(cnt)};
      default:      mem_addr = '0;
    endcase
  end

  assign mem_wdata = h_q[hidx] + v_q[hidx];
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/sha_ctx_engine.sv
module sha_ctx_engine
  import sha_ctx_pkg::*;
#(
  parameter int REG_DW      = 8,
  parameter int ALIGN_BYTES = 256,
  parameter int MEM_AW      = (REG_DW - 2) + $clog2(ALIGN_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);

  localparam int BASE_BITS = REG_DW - 2;

  logic                 busy;
  logic                 start;
  logic [BASE_BITS-1:0] ctx_base;
  logic [BASE_BITS-1:0] k_base;

  sha_ctx_regs #(.DW(REG_DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .rdata    (reg_rdata),
    .start    (start),
    .ctx_base (ctx_base),
    .k_base   (k_base)
  );

  sha_ctx_seq #(.BASE_BITS(BASE_BITS), .ALIGN_BYTES(ALIGN_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ctx_base  (ctx_base),
    .k_base    (k_base),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
  );

endmodule

// File: rtl/sha_ctx_engine_chk.sv
module sha_ctx_engine_chk #(
  parameter int REG_DW = 8,
  parameter int MEM_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready
);

  // R8: idle engine leaves the port quiet
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R7: a stalled request holds its contents
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5: writes only target context words 24..31 (offset bits [5:3] == 3)
  p_write_h_only_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[5:3] == 3'd3));

  // R3: an idle start write leads to busy two edges later
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == 2'd0 && reg_wdata[1] && !busy) |=> ##1 busy);

  // R3: start flag reads 1 while the engine runs
  p_flag_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_addr == 2'd0) |-> reg_rdata[1]);

  // R5: the last chaining write ends the memory traffic
  p_last_write_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready && mem_addr[2:0] == 3'd7) |=> !mem_req);

endmodule

bind sha_ctx_engine sha_ctx_engine_chk #(.REG_DW(REG_DW), .MEM_AW(MEM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/sha_ctx_engine_bench.sv
module sha_ctx_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RAM_WORDS  = 1024;
  localparam int MEM_AW     = 12;

  localparam logic [31:0] KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1,
    32'h923f82a4, 32'hab1c5ed5, 32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174, 32'he49b69c1, 32'hefbe4786,
    32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147,
    32'h06ca6351, 32'h14292967, 32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85, 32'ha2bfe8a1, 32'ha81a664b,
    32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a,
    32'h5b9cca4f, 32'h682e6ff3, 32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };
  localparam logic [31:0] IV [8] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };
  localparam logic [7:0] CTRL_KEEP = 8'hA5;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_wr_en;
  logic [1:0]        reg_addr;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;
  logic              mem_req;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic              mem_ready = 1'b1;
  logic [31:0]       mem_rdata;

  logic [31:0] ram [RAM_WORDS];
  logic [31:0] rdata_q = '0;
  int          wr_count = 0;
  int          oob_count = 0;
  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] msg   [16];
  logic [31:0] ref_h [8];

  sha_ctx_engine u_sha_ctx_engine (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model: read data returned one cycle after acceptance
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (int'(mem_addr) >= RAM_WORDS) oob_count <= oob_count + 1;
      if (mem_we) begin
        ram[mem_addr[9:0]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        rdata_q <= ram[mem_addr[9:0]];
      end
    end
  end
  assign mem_rdata = rdata_q;

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic ref_compress();
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    for (int t = 0; t < 16; t++) w[t] = msg[t];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = ref_h[i];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KTAB[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) ref_h[i] = ref_h[i] + v[i];
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load_block(input int base_w, input bit with_h);
    for (int i = 0; i < 16; i++) ram[base_w + i] = msg[i];
    for (int i = 0; i < 8; i++) ram[base_w + 16 + i] = 32'hC0DE0000 + i;
    if (with_h) for (int i = 0; i < 8; i++) ram[base_w + 24 + i] = ref_h[i];
  endtask

  task automatic run_block(input int base_w, input bit poke);
    logic [7:0] d;
    int snap;
    bit idle_ok;
    snap = wr_count;
    ref_compress();
    reg_write(2'd0, CTRL_KEEP | 8'h02);
    reg_read(2'd0, d);
    check(d == (CTRL_KEEP | 8'h02), "R3 start flag reads 1 after start", 32'(d), 32'(CTRL_KEEP | 8'h02));
    if (poke) begin
      repeat (20) @(negedge clk);
      reg_write(2'd0, CTRL_KEEP | 8'h02);   // R6: ignored while running
    end
    for (int i = 0; i < 20000; i++) begin
      reg_read(2'd0, d);
      if (!d[1]) break;
    end
    check(d == CTRL_KEEP, "R3 R2 flag clears, other bits kept", 32'(d), 32'(CTRL_KEEP));
    check(wr_count - snap == 8, "R5 R6 exactly eight writes", 32'(wr_count - snap), 32'd8);
    for (int i = 0; i < 8; i++)
      check(ram[base_w + 24 + i] === ref_h[i], "R4 chaining word", ram[base_w + 24 + i], ref_h[i]);
    for (int i = 0; i < 16; i++)
      check(ram[base_w + i] === msg[i], "R5 message word untouched", ram[base_w + i], msg[i]);
    for (int i = 0; i < 8; i++)
      check(ram[base_w + 16 + i] === 32'hC0DE0000 + i, "R5 reserved word untouched",
            ram[base_w + 16 + i], 32'hC0DE0000 + i);
    idle_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (mem_req) idle_ok = 1'b0;
    end
    check(idle_ok, "R8 no request while idle", 32'(idle_ok), 32'd1);
    // R6: a poked start must not have begun a second operation
    check(wr_count - snap == 8, "R6 no extra operation", 32'(wr_count - snap), 32'd8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int ctx_f, k_f;
    rst = 1'b1; reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    for (int i = 0; i < RAM_WORDS; i++) ram[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), d);
      check(d == 8'h00, "R1 register reset value", 32'(d), 32'h0);
    end
    check(!mem_req, "R1 request low after reset", 32'(mem_req), 32'h0);

    // R2: register layout
    reg_write(2'd0, CTRL_KEEP);
    reg_read(2'd0, d);
    check(d == CTRL_KEEP, "R2 control readback", 32'(d), 32'(CTRL_KEEP));
    reg_write(2'd1, 8'h13);
    reg_read(2'd1, d);
    check(d == 8'h10, "R2 context base low bits zero", 32'(d), 32'h10);
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, d);
    check(d == 8'hFC, "R2 constant base low bits zero", 32'(d), 32'hFC);

    // constants at word 512 (field 8) and word 0 (field 0)
    for (int i = 0; i < 64; i++) begin
      ram[512 + i] = KTAB[i];
      ram[i] = KTAB[i];
    end

    // R4: single block "abc", context at field 4 (word 256)
    reg_write(2'd1, 8'h10);
    reg_write(2'd2, 8'h20);
    for (int i = 0; i < 16; i++) msg[i] = 32'h0;
    msg[0] = 32'h61626380; msg[15] = 32'h00000018;
    for (int i = 0; i < 8; i++) ref_h[i] = IV[i];
    load_block(256, 1'b1);
    run_block(256, 1'b1);
    check(ram[256 + 24] == 32'hba7816bf, "R4 known digest first word", ram[256 + 24], 32'hba7816bf);
    check(ram[256 + 31] == 32'hf20015ad, "R4 known digest last word", ram[256 + 31], 32'hf20015ad);

    // R7 R9: two-block message with wait states, context at field 12 (word 768)
    stall_en = 1'b1;
    reg_write(2'd1, 8'h30);
    for (int i = 0; i < 14; i++) msg[i] = 32'h61626364 + 32'h01010101 * i;
    msg[14] = 32'h80000000; msg[15] = 32'h0;
    for (int i = 0; i < 8; i++) ref_h[i] = IV[i];
    load_block(768, 1'b1);
    run_block(768, 1'b0);
    for (int i = 0; i < 15; i++) msg[i] = 32'h0;
    msg[15] = 32'h000001c0;
    load_block(768, 1'b0);
    run_block(768, 1'b1);
    check(ram[768 + 24] == 32'h248d6a61, "R9 R7 chained digest first word", ram[768 + 24], 32'h248d6a61);
    check(ram[768 + 31] == 32'h19db06c1, "R9 R7 chained digest last word", ram[768 + 31], 32'h19db06c1);

    // sweep: bases, wait states and message patterns, chaining across runs
    for (int s = 0; s < 6; s++) begin
      stall_en = s[0];
      ctx_f = (s % 3 == 0) ? 4 : ((s % 3 == 1) ? 12 : 6);
      k_f   = (s[1]) ? 0 : 8;
      reg_write(2'd1, 8'(ctx_f << 2));
      reg_write(2'd2, 8'(k_f << 2));
      for (int i = 0; i < 16; i++)
        msg[i] = (32'(i + 1) * 32'h9E3779B9) ^ (32'(s + 3) * 32'h85EBCA6B);
      for (int i = 0; i < 8; i++) ref_h[i] = ram[ctx_f * 64 + 24 + i];
      load_block(ctx_f * 64, 1'b0);
      run_block(ctx_f * 64, s[0]);
    end
    check(oob_count == 0, "R5 accesses inside RAM", 32'(oob_count), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule